// File: doc/BRIEF.md
# SPI Serial Memory Slave

This block is the slave side of a four-wire serial memory port in front of a 512-byte register file. Chip select, serial clock and serial data in are oversampled by a fast system clock. Serial clock edges are recovered from the synchronized copy, so the whole block runs in the system clock domain. Each chip-select frame carries one command byte. The byte may be followed by an address and a stream of data bytes, and reads and writes may run for any length. Every written byte lands in the array as soon as its eighth bit arrives, so the port never reports busy.

A write-enable latch and a two-bit block-protect field live inside the block and are visible on ports. An external protection unit looks at them and at each write strobe, and returns an allow bit. The byte is stored only when that bit is high. Serial data out comes with a separate output enable so that a pad or a shared line can be tristated.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset, so_oe, wr_req and write_en are 0, blk_prot is 00, and every array byte reads back as 00h.
- R2: Command byte 06h sets the write-enable latch and 04h clears it. Both take effect when the eighth bit of the command is sampled.
- R3: Command 05h returns the status byte MSB first: bits 7:4 are 0, bits 3:2 are blk_prot, bit 1 is the write-enable latch and bit 0 is 0. Each bit is sampled on the rising serial clock edge and changes only after a falling edge.
- R4: Command 01h takes one more byte. Its bits 3:2 go to blk_prot only if the write-enable latch is set, and the command then clears the latch. All other bits of that byte have no effect.
- R5: Command 0000A010b followed by an address byte starts a write at address {A, address byte}. Each complete data byte gives a one-cycle wr_req with wr_addr and wr_data, and the array takes the byte only when wr_allow is high in that cycle.
- R6: Command 0000A011b followed by an address byte returns array data from address {A, address byte}, MSB first. Data on serial input is ignored while this data is being returned.
- R7: In both read and write streams the address steps by one after each byte and wraps from 1FFh to 000h.
- R8: Chip select going high returns the command decoder to idle, drops a partly shifted byte without writing it, and clears the write-enable latch if a write stream was open.
- R9: Only the first byte of a frame is decoded as a command. Bytes after a one-byte command change nothing.
- R10: so_oe is high only while a read or status stream is active under an asserted chip select.
- R11: A command byte matching none of the six encodings (including read/write forms with nonzero upper nibble) is ignored until chip select goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, mode 0 or mode 3 |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so |
| wr_req | output | 1 | One-cycle strobe for a complete write data byte |
| wr_addr | output | 9 | Target address of the strobed byte |
| wr_data | output | 8 | Strobed data byte |
| wr_allow | input | 1 | Protection unit permits the strobed byte |
| write_en | output | 1 | Current state of the write-enable latch |
| blk_prot | output | 2 | Current block-protect field |

## Verification
A wrong address counter or decode state shows up as wrong read bytes at so, or as a wrong wr_addr on the very next write strobe. Wrap errors appear on the byte right after 1FFh. A latch or protect field that holds the wrong value shows up at once on write_en and blk_prot, and again in the next status read. A stray output enable is caught at the first sample point of a frame that should never drive the line. Mode 3 frames are mixed with mode 0 frames so that an edge detector keyed to the idle clock level fails on the first bit of a frame.

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int ADDR_W = 9,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  output logic              so,
  output logic              so_oe,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  input  logic              wr_allow,
  output logic              write_en,
  output logic [1:0]        blk_prot
);
  localparam int DEPTH = 1 << ADDR_W;

  typedef enum logic [2:0] {ST_OP, ST_ADDR, ST_WDAT, ST_RDAT, ST_WSR, ST_RSR, ST_IGN} st_t;

  logic [SYNC_N-1:0] cs_q, sck_q, si_q;
  logic              sck_d;
  st_t               st;
  logic [2:0]        bitcnt;
  logic [6:0]        sh;
  logic              rd_cmd;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        obuf;
  logic              so_r;
  logic [7:0]        mem [DEPTH];

  wire cs_s  = cs_q[SYNC_N-1];
  wire sck_s = sck_q[SYNC_N-1];
  wire si_s  = si_q[SYNC_N-1];
  wire rise  = ~cs_s &  sck_s & ~sck_d;
  wire fall  = ~cs_s & ~sck_s &  sck_d;
  wire [7:0] byte_in   = {sh, si_s};
  wire       byte_done = rise && (bitcnt == 3'd7);
  wire [7:0] status    = {4'b0000, blk_prot, write_en, 1'b0};
  wire [ADDR_W-1:0] addr_nx = addr + ADDR_W'(1);

  assign wr_req  = byte_done && (st == ST_WDAT);
  assign wr_addr = addr;
  assign wr_data = byte_in;
  assign so      = so_r;
  assign so_oe   = ~cs_s && (st == ST_RDAT || st == ST_RSR);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q  <= '1;
      sck_q <= '0;
      si_q  <= '0;
      sck_d <= 1'b0;
    end else begin
      cs_q  <= {cs_q[SYNC_N-2:0], cs_n};
      sck_q <= {sck_q[SYNC_N-2:0], sck};
      si_q  <= {si_q[SYNC_N-2:0], si};
      sck_d <= sck_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_req && wr_allow) begin
      mem[addr] <= byte_in;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= ST_OP;
      bitcnt   <= '0;
      sh       <= '0;
      rd_cmd   <= 1'b0;
      addr     <= '0;
      obuf     <= '0;
      so_r     <= 1'b0;
      write_en <= 1'b0;
      blk_prot <= '0;
    end else if (cs_s) begin
      st     <= ST_OP;
      bitcnt <= '0;
      if (st == ST_WDAT) write_en <= 1'b0;
    end else begin
      if (rise) begin
        sh     <= byte_in[6:0];
        bitcnt <= bitcnt + 3'd1;
      end
      if (fall) so_r <= obuf[~bitcnt];
      if (byte_done) begin
        case (st)
          ST_OP: begin
            casez (byte_in)
              8'b0000_0110: begin write_en <= 1'b1; st <= ST_IGN; end
              8'b0000_0100: begin write_en <= 1'b0; st <= ST_IGN; end
              8'b0000_0101: begin obuf <= status; st <= ST_RSR; end
              8'b0000_0001: st <= ST_WSR;
              8'b0000_?011: begin rd_cmd <= 1'b1; addr[ADDR_W-1] <= byte_in[3]; st <= ST_ADDR; end
              8'b0000_?010: begin rd_cmd <= 1'b0; addr[ADDR_W-1] <= byte_in[3]; st <= ST_ADDR; end
              default:      st <= ST_IGN;
            endcase
          end
          ST_ADDR: begin
            addr[7:0] <= byte_in;
            if (rd_cmd) begin
              obuf <= mem[{addr[ADDR_W-1], byte_in}];
              st   <= ST_RDAT;
            end else begin
              st   <= ST_WDAT;
            end
          end
          ST_WDAT: addr <= addr_nx;
          ST_RDAT: begin
            addr <= addr_nx;
            obuf <= mem[addr_nx];
          end
          ST_WSR: begin
            if (write_en) begin
              blk_prot <= byte_in[3:2];
              write_en <= 1'b0;
            end
            st <= ST_IGN;
          end
          ST_RSR:  obuf <= status;
          default: ;
        endcase
      end
    end

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> !wr_req); // R5

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_addr == '1) |=> (wr_addr == '0)); // R7

  AST_PROT_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(blk_prot) |-> ($past(write_en) && !write_en)); // R4

  AST_LATCH_SET_BY_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(write_en) |-> ($past(st) == ST_OP)); // R2

  AST_IDLE_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (st == ST_OP && bitcnt == 3'd0)); // R8

  AST_OE_DROPS_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_s) |=> !so_oe); // R10
endmodule

// File: tb/sim_spi_mem_slave.sv
module sim_spi_mem_slave;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  wire so, so_oe, wr_req, write_en;
  wire [8:0] wr_addr;
  wire [7:0] wr_data;
  wire [1:0] blk_prot;
  logic wr_allow;

  localparam int H = 8;
  int total = 0, bad = 0;
  bit mode3 = 1'b0;
  logic [7:0] mmem [512];
  logic       mwel;
  logic [1:0] mbp;
  int         req_cnt = 0;
  logic [8:0] req_addr;
  logic [7:0] req_data;

  always #2 clk = ~clk;

  spi_mem_slave u0 (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .so(so),
    .so_oe(so_oe), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_allow(wr_allow), .write_en(write_en), .blk_prot(blk_prot));

  function automatic logic prot(input logic [8:0] a, input logic [1:0] b);
    case (b)
      2'd0:    return 1'b0;
      2'd1:    return a >= 9'h180;
      2'd2:    return a >= 9'h100;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] exp_status();
    return {4'b0000, mbp, mwel, 1'b0};
  endfunction

  assign wr_allow = write_en && !prot(wr_addr, blk_prot);

  always @(posedge clk)
    if (wr_req) begin
      req_cnt  <= req_cnt + 1;
      req_addr <= wr_addr;
      req_data <= wr_data;
    end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R1..: act=hung exp=finished");
    summary();
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, input int nb, output logic [7:0] rx, output int oes);
    rx = '0; oes = 0;
    for (int i = 0; i < nb; i++) begin
      sck = 1'b0; si = tx[7-i];
      tick(H);
      rx[7-i] = so;
      oes += so_oe;
      sck = 1'b1;
      tick(H);
    end
  endtask

  task automatic fstart();
    sck = mode3; tick(H);
    cs_n = 1'b0; tick(H);
  endtask

  task automatic fend();
    if (!mode3) sck = 1'b0;
    tick(H);
    cs_n = 1'b1;
    tick(2*H);
  endtask

  task automatic one_byte(input logic [7:0] op);
    logic [7:0] rx; int oes;
    fstart(); xfer(op, 8, rx, oes); fend();
  endtask

  task automatic wren();
    one_byte(8'h06); mwel = 1'b1;
    chk(write_en === 1'b1, "R2 set latch", write_en, 1);
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] rx; int oes;
    fstart(); xfer(8'h01, 8, rx, oes); xfer(v, 8, rx, oes); fend();
    if (mwel) mbp = v[3:2];
    mwel = 1'b0;
    chk(blk_prot === mbp, "R4 protect field", blk_prot, mbp);
    chk(write_en === 1'b0, "R4 latch cleared", write_en, 0);
  endtask

  task automatic rdsr();
    logic [7:0] rx, e; int oes;
    e = exp_status();
    fstart(); xfer(8'h05, 8, rx, oes); xfer(8'hA5, 8, rx, oes); fend();
    chk(rx === e, "R3 status byte", rx, e);
    chk(oes == 8, "R10 oe during status", oes, 8);
  endtask

  task automatic do_write(input logic [8:0] a, input int n);
    logic [7:0] rx, d; int oes, c0;
    c0 = req_cnt;
    fstart();
    xfer({4'b0000, a[8], 3'b010}, 8, rx, oes);
    xfer(a[7:0], 8, rx, oes);
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      xfer(d, 8, rx, oes);
      chk(req_addr === a && req_data === d, "R5 strobe addr/data", {req_addr, req_data}, {a, d});
      chk(oes == 0, "R10 no oe in write", oes, 0);
      if (mwel && !prot(a, mbp)) mmem[a] = d;
      a = a + 9'd1;
    end
    fend();
    chk(req_cnt == c0 + n, "R5 strobe count", req_cnt, c0 + n);
    mwel = 1'b0;
    chk(write_en === 1'b0, "R8 latch cleared after write", write_en, 0);
  endtask

  task automatic do_read(input logic [8:0] a, input int n, input string tag);
    logic [7:0] rx; int oes;
    fstart();
    xfer({4'b0000, a[8], 3'b011}, 8, rx, oes);
    xfer(a[7:0], 8, rx, oes);
    for (int k = 0; k < n; k++) begin
      xfer(8'($urandom), 8, rx, oes);
      chk(rx === mmem[a], tag, rx, mmem[a]);
      chk(oes == 8, "R10 oe in read", oes, 8);
      a = a + 9'd1;
    end
    fend();
    chk(so_oe === 1'b0, "R10 oe off after frame", so_oe, 0);
  endtask

  initial begin
    logic [7:0] rx; int oes, c0;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 512; i++) mmem[i] = 8'h00;
    mwel = 1'b0; mbp = 2'b00;
    tick(5); rst_n = 1'b1; tick(5);

    chk(so_oe === 1'b0 && wr_req === 1'b0, "R1 outputs idle", {so_oe, wr_req}, 0);
    chk(write_en === 1'b0 && blk_prot === 2'b00, "R1 latch/protect", {write_en, blk_prot}, 0);
    do_read(9'h000, 2, "R1 array cleared");
    do_read(9'h1FF, 1, "R1 array cleared top");

    rdsr();
    wren();
    rdsr();
    one_byte(8'h04); mwel = 1'b0;
    chk(write_en === 1'b0, "R2 clear latch", write_en, 0);

    do_write(9'h020, 2);
    do_read(9'h020, 2, "R5 blocked without latch");

    wren(); do_write(9'h1FE, 4);
    do_read(9'h1FE, 4, "R7 wrap read/write");
    mode3 = 1'b1;
    wren(); do_write(9'h0A5, 3);
    do_read(9'h0A5, 3, "R6 mode3 read");
    mode3 = 1'b0;

    wrsr(8'hFF);
    wren(); wrsr(8'hFF);
    rdsr();
    wren(); do_write(9'h010, 1);
    do_read(9'h010, 1, "R5 all protected");
    wren(); wrsr(8'hF7);
    chk(blk_prot === 2'b01, "R4 only bits 3:2", blk_prot, 1);
    wren(); do_write(9'h17E, 4);
    do_read(9'h17E, 4, "R5 upper quarter protected");
    wren(); wrsr(8'h00);

    wren();
    c0 = req_cnt;
    fstart();
    xfer(8'h02, 8, rx, oes); xfer(8'h40, 8, rx, oes);
    xfer(8'h3C, 8, rx, oes); xfer(8'hFF, 4, rx, oes);
    fend();
    mmem[9'h040] = 8'h3C; mwel = 1'b0;
    chk(req_cnt == c0 + 1, "R8 partial byte no strobe", req_cnt, c0 + 1);
    chk(write_en === 1'b0, "R8 latch cleared", write_en, 0);
    do_read(9'h040, 2, "R8 partial byte dropped");

    fstart(); xfer(8'h06, 8, rx, oes); xfer(8'h04, 8, rx, oes); fend();
    mwel = 1'b1;
    chk(write_en === 1'b1, "R9 second byte ignored", write_en, 1);
    fstart(); xfer(8'h04, 8, rx, oes); xfer(8'h06, 8, rx, oes); fend();
    mwel = 1'b0;
    chk(write_en === 1'b0, "R9 second byte ignored", write_en, 0);

    wren();
    fstart(); xfer(8'h13, 8, rx, oes); xfer(8'h00, 8, rx, oes); xfer(8'h04, 8, rx, oes);
    c0 = oes; fend();
    chk(c0 == 0 && write_en === 1'b1, "R11 bad read form ignored", {c0[3:0], write_en}, 1);
    fstart(); xfer(8'hC2, 8, rx, oes); xfer(8'h00, 8, rx, oes); xfer(8'h55, 8, rx, oes); fend();
    chk(oes == 0 && write_en === 1'b1, "R11 bad write form ignored", {oes[3:0], write_en}, 1);
    do_read(9'h000, 1, "R11 array unchanged");
    one_byte(8'h04); mwel = 1'b0;

    for (int it = 0; it < 18; it++) begin
      logic [8:0] a; int n;
      mode3 = 1'($urandom);
      a = 9'($urandom);
      n = 1 + int'($urandom % 4);
      if ($urandom % 4 == 0) begin wren(); wrsr(8'($urandom)); end
      if ($urandom % 3 != 0) wren();
      do_write(a, n);
      do_read(a, n, "R6 random read");
    end
    mode3 = 1'b0;
    rdsr();

    summary();
  end
endmodule